// File: doc/BRIEF.md
# Saturating Leaky Integrate-and-Fire Core

This block holds the membrane state of one spiking neuron. On every clock it adds an input current to an unsigned membrane potential and removes a programmable leak from it. The result is clamped at zero and at full scale, so it never wraps. A spike is issued only when the potential has reached a programmable threshold and an external random "permit" bit is high in that cycle. Firing is therefore a Bernoulli trial whose odds are set by a separate random source.

After a spike the potential returns to zero. A small hold counter then freezes the neuron for a programmable number of cycles, from zero to seven, which caps the output rate. Each operating value (current, threshold, leak, hold length) comes from one of two sets. One set arrives on parallel pins. The other set is held in registers by a host and is chosen by a mode input. This lets the neuron run either from a live datapath or entirely from stored settings.

Top module: `lif_core`

## Requirements
- R1: While reset is asserted, and on the first cycle after its release, `membrane` reads 0 and `spike` reads 0.
- R2: On a cycle with no spike and no hold, the next potential is min(2^16-1, max(0, V + current - decay)). A large current holds the potential at 0xFFFF and never wraps it to a small value.
- R3: When the leak exceeds the potential plus the current, the potential floors at 0 and never wraps to a large value.
- R4: A spike is produced only when the hold counter is zero, `stoch_event` is 1, and the present potential V satisfies V >= {threshold, 8'h00}, meaning the 8-bit threshold is placed in the upper byte of 16 bits. If `stoch_event` is 0, no spike occurs even when the potential is above threshold.
- R5: `spike` is a registered pulse that appears one clock after the firing decision. On that same clock edge `membrane` becomes 0.
- R6: After a spike taken with hold setting r, the next r cycles produce no spike and leave `membrane` unchanged.
- R7: With threshold 0 and `stoch_event` held at 1, starting from reset, the core fires exactly once every r+1 cycles for each r from 0 to 7.
- R8: `host_mode` = 1 takes current, threshold, decay and hold from the `reg_*` inputs and ignores the `pin_*` inputs. `host_mode` = 0 does the reverse.
- R9: With `stoch_event` held at 1 and zero leak, the spike count over a fixed window does not fall as the current rises, and does not rise as the threshold rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_mode | input | 1 | 1 selects the register set, 0 selects the pin set |
| pin_current | input | 8 | Input current, pin set |
| pin_threshold | input | 8 | Threshold (upper byte of 16 bits), pin set |
| pin_decay | input | 8 | Leak per cycle, pin set |
| pin_refr | input | 3 | Hold length after a spike, pin set |
| reg_current | input | 8 | Input current, register set |
| reg_threshold | input | 8 | Threshold, register set |
| reg_decay | input | 8 | Leak per cycle, register set |
| reg_refr | input | 3 | Hold length, register set |
| stoch_event | input | 1 | Random permit bit for firing |
| spike | output | 1 | One-cycle spike pulse |
| membrane | output | 16 | Membrane potential |

## Verification
Two actions can land in the same cycle: the potential crosses the threshold, and the hold counter reaches zero. When both happen, the core must fire. Integration must not run on that cycle. The bench provokes this case with threshold 0 and the permit bit held high, so each hold interval ends directly in a firing cycle. It judges the result with a cycle-exact scoreboard and by counting spikes per window for every hold length. A second collision pairs a full-scale potential with a permit bit that toggles, so saturation and firing meet on alternate cycles.

// File: rtl/lif_pkg.sv
package lif_pkg;
   typedef enum logic {
      SRC_PINS = 1'b0,
      SRC_HOST = 1'b1
   } lif_src_e;
endpackage

// File: rtl/lif_src_mux.sv
module lif_src_mux #(
   parameter int CUR_W = 8,
   parameter int THR_W = 8,
   parameter int DEC_W = 8,
   parameter int REF_W = 3
) (
   input  lif_pkg::lif_src_e sel,
   input  logic [CUR_W-1:0]  p_cur,
   input  logic [THR_W-1:0]  p_thr,
   input  logic [DEC_W-1:0]  p_dec,
   input  logic [REF_W-1:0]  p_ref,
   input  logic [CUR_W-1:0]  h_cur,
   input  logic [THR_W-1:0]  h_thr,
   input  logic [DEC_W-1:0]  h_dec,
   input  logic [REF_W-1:0]  h_ref,
   output logic [CUR_W-1:0]  o_cur,
   output logic [THR_W-1:0]  o_thr,
   output logic [DEC_W-1:0]  o_dec,
   output logic [REF_W-1:0]  o_ref
);
   always_comb begin
      if (sel == lif_pkg::SRC_HOST) begin
         o_cur = h_cur;
         o_thr = h_thr;
         o_dec = h_dec;
         o_ref = h_ref;
      end else begin
         o_cur = p_cur;
         o_thr = p_thr;
         o_dec = p_dec;
         o_ref = p_ref;
      end
   end
endmodule

// File: rtl/lif_integ.sv
module lif_integ #(
   parameter int POT_W = 16,
   parameter int CUR_W = 8,
   parameter int DEC_W = 8
) (
   input  logic [POT_W-1:0] pot,
   input  logic [CUR_W-1:0] cur,
   input  logic [DEC_W-1:0] dec,
   output logic [POT_W-1:0] pot_next
);
   localparam int EXT_W = POT_W + 2;
   localparam logic signed [EXT_W-1:0] TOP = $signed({2'b00, {POT_W{1'b1}}});

   logic signed [EXT_W-1:0] raw;

   always_comb begin
      raw = $signed({2'b00, pot})
          + $signed({{(EXT_W-CUR_W){1'b0}}, cur})
          - $signed({{(EXT_W-DEC_W){1'b0}}, dec});
      if (raw < 0)
         pot_next = '0;
      else if (raw > TOP)
         pot_next = '1;
      else
         pot_next = raw[POT_W-1:0];
   end
endmodule

// File: rtl/lif_refr.sv
module lif_refr #(
   parameter int REF_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [REF_W-1:0] load_val,
   output logic             busy,
   output logic [REF_W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (load)
         count <= load_val;
      else if (count != '0)
         count <= count - 1'b1;
   end

   assign busy = (count != '0);
endmodule

// File: rtl/lif_core.sv
module lif_core #(
   parameter int POT_W = 16,
   parameter int CUR_W = 8,
   parameter int THR_W = 8,
   parameter int DEC_W = 8,
   parameter int REF_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_mode,
   input  logic [CUR_W-1:0] pin_current,
   input  logic [THR_W-1:0] pin_threshold,
   input  logic [DEC_W-1:0] pin_decay,
   input  logic [REF_W-1:0] pin_refr,
   input  logic [CUR_W-1:0] reg_current,
   input  logic [THR_W-1:0] reg_threshold,
   input  logic [DEC_W-1:0] reg_decay,
   input  logic [REF_W-1:0] reg_refr,
   input  logic             stoch_event,
   output logic             spike,
   output logic [POT_W-1:0] membrane
);
   localparam int THR_SHIFT = POT_W - THR_W;

   if (THR_W > POT_W) begin : g_bad_thr
      $error("threshold wider than membrane");
   end
   if (CUR_W > POT_W || DEC_W > POT_W) begin : g_bad_in
      $error("current or decay wider than membrane");
   end

   logic [CUR_W-1:0] cur_s;
   logic [THR_W-1:0] thr_s;
   logic [DEC_W-1:0] dec_s;
   logic [REF_W-1:0] refr_s;
   logic [POT_W-1:0] thr_full;
   logic [POT_W-1:0] pot_q;
   logic [POT_W-1:0] pot_nx;
   logic             spike_q;
   logic             fire;
   logic             hold;
   logic [REF_W-1:0] refr_cnt;
   lif_pkg::lif_src_e src;

   assign src = host_mode ? lif_pkg::SRC_HOST : lif_pkg::SRC_PINS;

   lif_src_mux #(
      .CUR_W(CUR_W), .THR_W(THR_W), .DEC_W(DEC_W), .REF_W(REF_W)
   ) u_mux (
      .sel  (src),
      .p_cur(pin_current), .p_thr(pin_threshold),
      .p_dec(pin_decay),   .p_ref(pin_refr),
      .h_cur(reg_current), .h_thr(reg_threshold),
      .h_dec(reg_decay),   .h_ref(reg_refr),
      .o_cur(cur_s), .o_thr(thr_s), .o_dec(dec_s), .o_ref(refr_s)
   );

   if (THR_SHIFT == 0) begin : g_thr_same
      assign thr_full = thr_s;
   end else begin : g_thr_scaled
      assign thr_full = {thr_s, {THR_SHIFT{1'b0}}};
   end

   lif_integ #(
      .POT_W(POT_W), .CUR_W(CUR_W), .DEC_W(DEC_W)
   ) u_integ (
      .pot     (pot_q),
      .cur     (cur_s),
      .dec     (dec_s),
      .pot_next(pot_nx)
   );

   lif_refr #(.REF_W(REF_W)) u_refr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (fire),
      .load_val(refr_s),
      .busy    (hold),
      .count   (refr_cnt)
   );

   assign fire = !hold && stoch_event && (pot_q >= thr_full);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pot_q   <= '0;
         spike_q <= 1'b0;
      end else begin
         spike_q <= fire;
         if (fire)
            pot_q <= '0;
         else if (!hold)
            pot_q <= pot_nx;
      end
   end

   assign spike    = spike_q;
   assign membrane = pot_q;
endmodule

// File: rtl/lif_core_chk.sv
module lif_core_chk #(
   parameter int POT_W = 16,
   parameter int CUR_W = 8,
   parameter int DEC_W = 8,
   parameter int REF_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             spike,
   input logic [POT_W-1:0] membrane,
   input logic             stoch_event,
   input logic [CUR_W-1:0] cur_sel,
   input logic [DEC_W-1:0] dec_sel,
   input logic [POT_W-1:0] thr_full,
   input logic [REF_W-1:0] refr_sel,
   input logic [REF_W-1:0] cnt
);
   // R2: a fall in potential without a spike needs leak above current
   a_r2_no_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
      (!spike && membrane < $past(membrane)) |-> ($past(cur_sel) < $past(dec_sel)));

   // R3: a rise in potential needs current above leak
   a_r3_no_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
      (membrane > $past(membrane)) |-> ($past(cur_sel) > $past(dec_sel)));

   // R4: firing needs the permit bit and the threshold met on the previous cycle
   a_r4_fire_gate: assert property (@(posedge clk) disable iff (!rst_n)
      spike |-> ($past(stoch_event) && $past(membrane) >= $past(thr_full)));

   // R5: a spike arrives together with a cleared potential
   a_r5_spike_clears: assert property (@(posedge clk) disable iff (!rst_n)
      spike |-> (membrane == '0));

   // R6: hold counter picks up the setting present at the firing decision
   a_r6_hold_load: assert property (@(posedge clk) disable iff (!rst_n)
      spike |-> (cnt == $past(refr_sel)));

   // R6: while holding, no spike and no movement of the potential
   a_r6_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cnt) != '0) |-> (!spike && $stable(membrane)));
endmodule

bind lif_core lif_core_chk #(
   .POT_W(POT_W), .CUR_W(CUR_W), .DEC_W(DEC_W), .REF_W(REF_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .spike      (spike),
   .membrane   (membrane),
   .stoch_event(stoch_event),
   .cur_sel    (cur_s),
   .dec_sel    (dec_s),
   .thr_full   (thr_full),
   .refr_sel   (refr_s),
   .cnt        (refr_cnt)
);

// File: tb/test_lif_core.sv
module test_lif_core;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_mode = 1'b0;
   logic [7:0]  pin_current = '0, pin_threshold = '0, pin_decay = '0;
   logic [2:0]  pin_refr = '0;
   logic [7:0]  reg_current = '0, reg_threshold = '0, reg_decay = '0;
   logic [2:0]  reg_refr = '0;
   logic        stoch_event = 1'b0;
   logic        spike;
   logic [15:0] membrane;

   int vectors = 0;
   int fails   = 0;
   int spk_seen = 0;

   typedef struct {
      logic        spk;
      logic [15:0] mem;
      string       req;
   } exp_t;
   exp_t q[$];

   logic [15:0] m_v = '0;
   logic [2:0]  m_cnt = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lif_core i_lif_core (
      .clk(clk), .rst_n(rst_n), .host_mode(host_mode),
      .pin_current(pin_current), .pin_threshold(pin_threshold),
      .pin_decay(pin_decay), .pin_refr(pin_refr),
      .reg_current(reg_current), .reg_threshold(reg_threshold),
      .reg_decay(reg_decay), .reg_refr(reg_refr),
      .stoch_event(stoch_event), .spike(spike), .membrane(membrane)
   );

   task automatic check_val(input int act, input int exp, input string req);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // monitor: pops one expectation per clock, away from the edge
   always @(posedge clk) begin
      #(CLK_PERIOD/4);
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         vectors++;
         if (spike) spk_seen++;
         if (spike !== e.spk || membrane !== e.mem) begin
            fails++;
            $display("FAIL %s: actual spike=%0b mem=%0d expected spike=%0b mem=%0d",
                     e.req, spike, membrane, e.spk, e.mem);
         end
      end
   end

   // driver: called at a falling edge, predicts the next edge, returns at the next falling edge
   task automatic step(input logic ev, input string req);
      int   cur, thr, dec, rf, sum;
      exp_t e;
      stoch_event = ev;
      cur = host_mode ? reg_current   : pin_current;
      thr = host_mode ? reg_threshold : pin_threshold;
      dec = host_mode ? reg_decay     : pin_decay;
      rf  = host_mode ? reg_refr      : pin_refr;
      if (m_cnt == 0 && ev && int'(m_v) >= thr * 256) begin
         m_v = '0;
         m_cnt = 3'(rf);
         e.spk = 1'b1;
      end else if (m_cnt != 0) begin
         m_cnt = m_cnt - 1'b1;
         e.spk = 1'b0;
      end else begin
         sum = int'(m_v) + cur - dec;
         if (sum < 0) sum = 0;
         if (sum > 65535) sum = 65535;
         m_v = 16'(sum);
         e.spk = 1'b0;
      end
      e.mem = m_v;
      e.req = req;
      q.push_back(e);
      @(negedge clk);
   endtask

   task automatic do_reset();
      while (q.size() > 0) @(negedge clk);
      @(negedge clk);
      rst_n = 1'b0;
      m_v = '0;
      m_cnt = '0;
      #1;
      check_val(membrane, 0, "R1");
      check_val(spike, 0, "R1");
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic set_pins(input int c, input int t, input int d, input int r);
      pin_current = 8'(c); pin_threshold = 8'(t); pin_decay = 8'(d); pin_refr = 3'(r);
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   function automatic int drain_count();
      return spk_seen;
   endfunction

   int c_lo, c_mid, c_hi, base;

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
   end

   initial begin
      repeat (2) @(negedge clk);
      #1;
      check_val(membrane, 0, "R1");
      check_val(spike, 0, "R1");
      rst_n = 1'b1;
      @(negedge clk);
      step(1'b0, "R1");

      // R2: saturate at full scale, permit low
      set_pins(255, 255, 0, 0);
      for (int i = 0; i < 300; i++) step(1'b0, "R2");
      // R4: above threshold but permit low -> no spike; then toggle permit
      set_pins(255, 200, 0, 2);
      for (int i = 0; i < 5; i++) step(1'b0, "R4");
      for (int i = 0; i < 40; i++) step(1'(i % 2), "R4");
      // R3: leak larger than current floors at zero
      set_pins(3, 255, 200, 0);
      for (int i = 0; i < 30; i++) step(1'b0, "R3");
      set_pins(60, 255, 61, 0);
      for (int i = 0; i < 10; i++) step(1'b0, "R2");

      // R5 / R6: firing with hold lengths
      set_pins(100, 2, 0, 5);
      for (int i = 0; i < 60; i++) step(1'b1, "R6");
      set_pins(100, 2, 0, 7);
      for (int i = 0; i < 60; i++) step(1'(i % 3 != 0), "R5");

      // R7: maximum rate for every hold setting
      for (int r = 0; r < 8; r++) begin
         do_reset();
         set_pins(0, 0, 0, r);
         base = spk_seen;
         for (int i = 0; i < 8 * (r + 1); i++) step(1'b1, "R7");
         while (q.size() > 0) @(negedge clk);
         check_val(spk_seen - base, 8, "R7");
      end

      // R8: host set in charge, pins scrambled while running
      do_reset();
      host_mode = 1'b1;
      reg_current = 8'd90; reg_threshold = 8'd3; reg_decay = 8'd10; reg_refr = 3'd2;
      set_pins(1, 0, 255, 7);
      for (int i = 0; i < 40; i++) begin
         set_pins(i * 7, i * 3, i * 11, i);
         step(1'b1, "R8");
      end
      host_mode = 1'b0;
      set_pins(5, 255, 0, 0);
      for (int i = 0; i < 10; i++) begin
         reg_current = 8'(i * 13); reg_decay = 8'(200 - i);
         step(1'b0, "R8");
      end

      // R9: rate against current and threshold
      do_reset();
      set_pins(8, 64, 0, 0);  base = spk_seen;
      for (int i = 0; i < 1000; i++) step(1'b1, "R9");
      while (q.size() > 0) @(negedge clk);
      c_lo = spk_seen - base;
      do_reset();
      set_pins(32, 64, 0, 0); base = spk_seen;
      for (int i = 0; i < 1000; i++) step(1'b1, "R9");
      while (q.size() > 0) @(negedge clk);
      c_mid = spk_seen - base;
      do_reset();
      set_pins(128, 64, 0, 0); base = spk_seen;
      for (int i = 0; i < 1000; i++) step(1'b1, "R9");
      while (q.size() > 0) @(negedge clk);
      c_hi = spk_seen - base;
      check_val(int'(c_lo <= c_mid && c_mid <= c_hi && c_hi > c_lo), 1, "R9");
      do_reset();
      set_pins(128, 16, 0, 0); base = spk_seen;
      for (int i = 0; i < 1000; i++) step(1'b1, "R9");
      while (q.size() > 0) @(negedge clk);
      c_lo = spk_seen - base;
      check_val(int'(c_lo > c_hi), 1, "R9");

      while (q.size() > 0) @(negedge clk);
      finish_run();
   end
endmodule